// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This peripheral supervises software with a 64-bit up-counter and a 64-bit
limit. Software sets them up over a simple 32-bit register bus, with each
64-bit quantity split into a low word and a high word. It then arms the
supervisor by writing two 16-bit keys in order. From that point the setup is
frozen.

Software must keep proving it is alive by writing the same two keys again.
That key pair zeroes the counter. If the counter reaches the limit, the block
raises a sticky expiry flag and drives a reset request for a fixed number of
clocks. A key out of order does the same at once.

The limit is the intended timeout multiplied by the counter clock rate. Only
the hardware reset input can take the block back to its idle, unlocked state.

Top module: `wdt64_guard`

## Requirements
- R1: Register map (byte offsets): counter low word 0x10, counter high word 0x14, limit low word 0x18, limit high word 0x1C, run control 0x20 (bits 7:6 stored, all others read 0), mode control 0x24 (bits 3:0 stored, all others read 0), guard control 0x28. Guard control reads with bit 15 as the expiry flag, bit 14 as the armed indication and all other bits as 0. Any other offset reads 0. After reset every register reads 0 and the reset output is low.
- R2: The counter advances by exactly one per clock when run control bits 7:6 are nonzero, mode control bits 3:2 equal 2 and mode control bits 1:0 are both 1. A counter half whose release bit is 0 (bit 0 for the low word, bit 1 for the high word) reads 0. With run control bits 7:6 at 0 the counter holds its value.
- R3: While idle, a guard control write with key field (bits 31:16) 0xA5C6 and bit 14 set moves the block to the pre-armed state. A following write of key 0xDA7E moves it to the armed state. Guard control bit 14 reads 1 from pre-armed onward.
- R4: From pre-armed onward, writes to the counter, limit, run control and mode control registers leave them unchanged.
- R5: In the armed state, key 0xA5C6 followed by key 0xDA7E zeroes the counter on the edge of the second write. A block serviced this way before the limit is reached never expires.
- R6: While pre-armed, armed or mid-service, a guard control write whose key is not the next expected key sets the expiry flag and starts the reset output on that clock edge.
- R7: While idle, guard control writes with any other key, or with key 0xA5C6 but bit 14 clear, change nothing.
- R8: In the armed or mid-service state, a counter value at or above the limit sets the expiry flag on the next edge. A limit of zero expires one clock after arming. The flag then stays set.
- R9: Each expiry drives the reset output high for exactly 16 consecutive clocks, and only once. After expiry, key writes have no effect.
- R10: Software cannot return the block to idle. A key pair written with bit 14 clear still leaves it armed. Only the hardware reset input clears the state, the flag and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational, no side effects |
| wd_rst_out | output | 1 | Reset request, high for PULSE_LEN clocks on expiry |

## Verification
The key handshake is tried with several patterns:
- the correct pair;
- the correct pair with the enable bit clear;
- a repeated first key;
- a second key with no first key;
- an arbitrary key.

These patterns separate a handshake that checks order from one that only checks membership in the key set. Counter expiry is exercised with a serviced run, an unserviced run timed to the exact clock, and a zero limit. Together these tell a greater-or-equal compare from an equality compare and show where the off-by-one lands. Writes to the configuration registers are repeated before and after arming, which separates the locked behaviour from the unlocked behaviour.

// File: rtl/wdt64_pkg.sv
package wdt64_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int KEY_W  = 16;

    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;
    localparam logic [7:0] OFS_LIM_LO = 8'h18;
    localparam logic [7:0] OFS_LIM_HI = 8'h1C;
    localparam logic [7:0] OFS_RUN    = 8'h20;
    localparam logic [7:0] OFS_MODE   = 8'h24;
    localparam logic [7:0] OFS_GUARD  = 8'h28;

    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hA5C6;
    localparam logic [KEY_W-1:0] KEY_CLOSE = 16'hDA7E;
    localparam logic [1:0]       MODE_WD64 = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_RUN  = 2'd2,
        ST_SVC  = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic [1:0] tmode;
        logic       rel_hi;
        logic       rel_lo;
    } mode_cfg_t;

    function automatic logic [KEY_W-1:0] expected_key(wd_state_e s);
        return (s == ST_PRE || s == ST_SVC) ? KEY_CLOSE : KEY_OPEN;
    endfunction

    function automatic wd_state_e step_state(wd_state_e s);
        case (s)
            ST_IDLE: return ST_PRE;
            ST_PRE:  return ST_RUN;
            ST_RUN:  return ST_SVC;
            default: return ST_RUN;
        endcase
    endfunction

endpackage

// File: rtl/wdt64_keyfsm.sv
module wdt64_keyfsm
    import wdt64_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key,
    input  logic             en_bit,
    input  logic             halted,
    output wd_state_e        state,
    output logic             key_bad,
    output logic             svc_done
);

    logic act;
    logic key_ok;
    logic advance;

    always_comb begin
        act      = key_wr && !halted;
        key_ok   = (key == expected_key(state));
        key_bad  = act && (state != ST_IDLE) && !key_ok;
        svc_done = act && (state == ST_SVC) && key_ok;
        advance  = act && key_ok && ((state != ST_IDLE) || en_bit);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else if (advance)
            state <= step_state(state);
    end

endmodule

// File: rtl/wdt64_count.sv
module wdt64_count
    import wdt64_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              clear,
    input  logic [1:0]        wr_cnt,
    input  logic [1:0]        wr_lim,
    input  logic [1:0]        rel,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  lim
);

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = run ? cnt + CNT_W'(1) : cnt;
        for (int h = 0; h < 2; h++) begin
            if (wr_cnt[h])
                cnt_nxt[h*DATA_W +: DATA_W] = wdata;
        end
        if (clear)
            cnt_nxt = '0;
        for (int h = 0; h < 2; h++) begin
            if (!rel[h])
                cnt_nxt[h*DATA_W +: DATA_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lim
        always_ff @(posedge clk) begin
            if (rst)
                lim[g*DATA_W +: DATA_W] <= '0;
            else if (wr_lim[g])
                lim[g*DATA_W +: DATA_W] <= wdata;
        end
    end

endmodule

// File: rtl/wdt64_rstgen.sv
module wdt64_rstgen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    output logic flag,
    output logic rst_out
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            left <= '0;
        end else if (trip && !flag) begin
            flag <= 1'b1;
            left <= PW'(PULSE_LEN);
        end else if (left != '0) begin
            left <= left - PW'(1);
        end
    end

    assign rst_out = (left != '0);

endmodule

// File: rtl/wdt64_guard.sv
module wdt64_guard
    import wdt64_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_rst_out
);

    wd_state_e        st;
    logic             key_bad;
    logic             svc_done;
    logic             flag;
    logic             unlocked;
    logic             armed;
    logic             run;
    logic             trip;
    logic [1:0]       run_mode;
    mode_cfg_t        mcfg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [1:0]       wr_cnt;
    logic [1:0]       wr_lim;

    function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign unlocked = (st == ST_IDLE);
    assign armed    = (st == ST_RUN) || (st == ST_SVC);
    assign run      = (run_mode != 2'b00) && (mcfg.tmode == MODE_WD64)
                      && mcfg.rel_lo && mcfg.rel_hi;
    assign trip     = key_bad || (armed && (cnt >= lim));

    always_comb begin
        wr_cnt[0] = bus_wr && unlocked && hit(bus_addr, OFS_CNT_LO);
        wr_cnt[1] = bus_wr && unlocked && hit(bus_addr, OFS_CNT_HI);
        wr_lim[0] = bus_wr && unlocked && hit(bus_addr, OFS_LIM_LO);
        wr_lim[1] = bus_wr && unlocked && hit(bus_addr, OFS_LIM_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_mode <= 2'b00;
            mcfg     <= '0;
        end else if (bus_wr && unlocked) begin
            if (hit(bus_addr, OFS_RUN))
                run_mode <= bus_wdata[7:6];
            if (hit(bus_addr, OFS_MODE))
                mcfg <= mode_cfg_t'(bus_wdata[3:0]);
        end
    end

    wdt64_keyfsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (bus_wr && hit(bus_addr, OFS_GUARD)),
        .key      (bus_wdata[31:16]),
        .en_bit   (bus_wdata[14]),
        .halted   (flag),
        .state    (st),
        .key_bad  (key_bad),
        .svc_done (svc_done)
    );

    wdt64_count u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .clear  (svc_done),
        .wr_cnt (wr_cnt),
        .wr_lim (wr_lim),
        .rel    ({mcfg.rel_hi, mcfg.rel_lo}),
        .wdata  (bus_wdata),
        .cnt    (cnt),
        .lim    (lim)
    );

    wdt64_rstgen #(.PULSE_LEN(PULSE_LEN)) u_rst (
        .clk     (clk),
        .rst     (rst),
        .trip    (trip),
        .flag    (flag),
        .rst_out (wd_rst_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFS_CNT_LO))     bus_rdata = cnt[DATA_W-1:0];
        else if (hit(bus_addr, OFS_CNT_HI)) bus_rdata = cnt[CNT_W-1:DATA_W];
        else if (hit(bus_addr, OFS_LIM_LO)) bus_rdata = lim[DATA_W-1:0];
        else if (hit(bus_addr, OFS_LIM_HI)) bus_rdata = lim[CNT_W-1:DATA_W];
        else if (hit(bus_addr, OFS_RUN))    bus_rdata = {24'h0, run_mode, 6'h0};
        else if (hit(bus_addr, OFS_MODE))   bus_rdata = {28'h0, mcfg};
        else if (hit(bus_addr, OFS_GUARD))  bus_rdata = {16'h0, flag, !unlocked, 14'h0};
    end

endmodule

// File: rtl/wdt64_guard_chk.sv
module wdt64_guard_chk
    import wdt64_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PULSE_LEN = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input wd_state_e         state,
    input logic              flag,
    input logic              rst_out,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  lim
);

    localparam int HW = $clog2(PULSE_LEN + 2) + 1;

    logic          key_wr;
    logic          armed;
    logic [HW-1:0] hi_run;

    assign key_wr = bus_wr && (bus_addr == ADDR_W'(OFS_GUARD));
    assign armed  = (state == ST_RUN) || (state == ST_SVC);

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= '0;
        else
            hi_run <= rst_out ? hi_run + HW'(1) : '0;
    end

    assert_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && bus_wr && bus_addr == ADDR_W'(OFS_LIM_LO))
        |=> $stable(lim[DATA_W-1:0]));

    assert_service_R5: assert property (@(posedge clk) disable iff (rst)
        (!flag && state == ST_SVC && key_wr && bus_wdata[31:16] == KEY_CLOSE)
        |=> (cnt == '0));

    assert_badkey_R6: assert property (@(posedge clk) disable iff (rst)
        (!flag && state != ST_IDLE && key_wr && bus_wdata[31:16] != expected_key(state))
        |=> (flag && rst_out));

    assert_expire_R8: assert property (@(posedge clk) disable iff (rst)
        (!flag && armed && cnt >= lim) |=> flag);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag);

    assert_pulse_len_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> (hi_run == HW'(PULSE_LEN)));

    assert_pulse_flag_R9: assert property (@(posedge clk) disable iff (rst)
        rst_out |-> flag);

    assert_no_disable_R10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (state != ST_IDLE));

endmodule

bind wdt64_guard wdt64_guard_chk #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .state     (st),
    .flag      (flag),
    .rst_out   (wd_rst_out),
    .cnt       (cnt),
    .lim       (lim)
);

// File: tb/wdt64_guard_tb.sv
module wdt64_guard_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wd_rst_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt64_guard u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wd_rst_out (wd_rst_out)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    // wr=1: write data; wr=0: read and compare with data. req 1 = R1, 2 = R2
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h24, 32'h0000_0000, 4'd1},
        '{1'b1, 8'h24, 32'h0000_0000, 4'd2},
        '{1'b1, 8'h10, 32'h0000_0055, 4'd2},
        '{1'b0, 8'h10, 32'h0000_0000, 4'd2},
        '{1'b1, 8'h24, 32'h0000_00FF, 4'd1},
        '{1'b0, 8'h24, 32'h0000_000F, 4'd1},
        '{1'b1, 8'h10, 32'h0000_0055, 4'd2},
        '{1'b0, 8'h10, 32'h0000_0055, 4'd2},
        '{1'b1, 8'h14, 32'h0000_0007, 4'd1},
        '{1'b0, 8'h14, 32'h0000_0007, 4'd1},
        '{1'b1, 8'h18, 32'h1234_5678, 4'd1},
        '{1'b0, 8'h18, 32'h1234_5678, 4'd1},
        '{1'b1, 8'h1C, 32'h0000_0009, 4'd1},
        '{1'b0, 8'h1C, 32'h0000_0009, 4'd1},
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 4'd1},
        '{1'b0, 8'h20, 32'h0000_00C0, 4'd1},
        '{1'b1, 8'h20, 32'h0000_0000, 4'd1},
        '{1'b0, 8'h00, 32'h0000_0000, 4'd1},
        '{1'b0, 8'h04, 32'h0000_0000, 4'd1},
        '{1'b0, 8'h2C, 32'h0000_0000, 4'd1},
        '{1'b0, 8'h28, 32'h0000_0000, 4'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic key(input logic [15:0] k, input logic en);
        wr(8'h28, {k, 1'b0, en, 14'h0});
    endtask

    task automatic setup(input logic [31:0] lim_lo);
        wr(8'h24, 32'hB);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0);
        wr(8'h18, lim_lo);
        wr(8'h1C, 32'h0);
        wr(8'h20, 32'h80);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a0, a1;
        int n, h;
        hw_reset();

        // R1 reset state
        rd(8'h18, v); check("R1 reset limit", v, 32'h0);
        rd(8'h28, v); check("R1 reset guard", v, 32'h0);
        check("R1 reset output", {31'h0, wd_rst_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].addr, VEC[i].data);
            end else begin
                rd(VEC[i].addr, v);
                n_chk++;
                if (v !== VEC[i].data) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d: got %h expected %h",
                             VEC[i].req, i, v, VEC[i].data);
                end
            end
        end

        // R2 counting one per clock, in both nonzero run modes
        wr(8'h24, 32'hB);
        wr(8'h20, 32'h80);
        rd(8'h10, a0); rd(8'h10, a1);
        check("R2 step continuous", a1 - a0, 32'h1);
        wr(8'h20, 32'h40);
        rd(8'h10, a0); rd(8'h10, a1);
        check("R2 step one-shot", a1 - a0, 32'h1);

        // R7 idle ignores wrong keys and missing enable
        key(16'h1111, 1'b1);
        key(16'hA5C6, 1'b0);
        rd(8'h28, v); check("R7 guard stays idle", v, 32'h0);
        check("R7 no reset", {31'h0, wd_rst_out}, 32'h0);
        wr(8'h18, 32'h77);
        rd(8'h18, v); check("R7 still unlocked", v, 32'h77);

        // R3 arming, R4 lock
        setup(32'd200);
        key(16'hA5C6, 1'b1);
        rd(8'h28, v); check("R3 pre-armed enable bit", v, 32'h4000);
        wr(8'h18, 32'h5);
        rd(8'h18, v); check("R4 limit locked", v, 32'd200);
        wr(8'h20, 32'h0);
        rd(8'h20, v); check("R4 run control locked", v, 32'h80);
        wr(8'h24, 32'h0);
        rd(8'h24, v); check("R4 mode control locked", v, 32'hB);
        key(16'hDA7E, 1'b1);
        rd(8'h28, v); check("R3 armed", v, 32'h4000);

        // R5 servicing, R10 enable bit clear does not disarm
        h = 0;
        for (int s = 0; s < 10; s++) begin
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                #1 if (wd_rst_out) h++;
            end
            key(16'hA5C6, 1'b0);
            key(16'hDA7E, 1'b0);
        end
        check("R5 no expiry while serviced", h, 0);
        rd(8'h10, v); check("R5 counter restarted", v, 32'h1);
        rd(8'h28, v); check("R10 still armed", v, 32'h4000);

        // R8 exact expiry time, R9 pulse length
        key(16'hA5C6, 1'b1);
        key(16'hDA7E, 1'b1);
        n = 0;
        #1;
        while (!wd_rst_out && n < 1000) begin
            @(negedge clk);
            #1 n++;
        end
        check("R8 expiry clocks after service", n, 201);
        h = 1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            #1 if (wd_rst_out) h++;
        end
        check("R9 pulse length once", h, 16);
        rd(8'h28, v); check("R8 flag sticky", v, 32'hC000);
        key(16'h1234, 1'b1);
        #1 check("R9 keys ignored after expiry", {31'h0, wd_rst_out}, 32'h0);

        // R10 hardware reset clears
        hw_reset();
        rd(8'h28, v); check("R10 reset clears guard", v, 32'h0);
        wr(8'h18, 32'h33);
        rd(8'h18, v); check("R10 reset unlocks", v, 32'h33);

        // R6 arbitrary key while armed
        setup(32'd5000);
        key(16'hA5C6, 1'b1);
        key(16'hDA7E, 1'b1);
        key(16'h1234, 1'b1);
        #1 check("R6 bad key in armed", {31'h0, wd_rst_out}, 32'h1);
        rd(8'h28, v); check("R6 flag after bad key", v, 32'hC000);

        // R6 repeated first key while pre-armed
        hw_reset();
        setup(32'd5000);
        key(16'hA5C6, 1'b1);
        key(16'hA5C6, 1'b1);
        #1 check("R6 repeat key in pre-armed", {31'h0, wd_rst_out}, 32'h1);

        // R6 second key without first while armed
        hw_reset();
        setup(32'd5000);
        key(16'hA5C6, 1'b1);
        key(16'hDA7E, 1'b1);
        key(16'hDA7E, 1'b1);
        #1 check("R6 close key out of order", {31'h0, wd_rst_out}, 32'h1);

        // R8 zero limit expires one clock after arming
        hw_reset();
        setup(32'd0);
        key(16'hA5C6, 1'b1);
        #1 check("R8 no expiry while pre-armed", {31'h0, wd_rst_out}, 32'h0);
        key(16'hDA7E, 1'b1);
        #1 check("R8 zero limit not yet", {31'h0, wd_rst_out}, 32'h0);
        @(negedge clk);
        #1 check("R8 zero limit next clock", {31'h0, wd_rst_out}, 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule